// File: doc/BRIEF.md
# Performance Event Counter Bank

This block keeps a set of general-purpose event counters and one free-running cycle counter for a processor core. Each general counter has its own configuration word. That word holds an event select and five privilege filter bits. The select picks one line from a bank of single-cycle event pulse inputs, or picks software increments written over the register port. The filter bits are compared against the current privilege level and security state, and a matching counter skips the event.

Software drives the block through a flat register port. A write takes effect at the clock edge. A read is combinational from the same address. A control register holds the master run bit, two one-shot clear commands and a divide-by-64 option for the cycle counter. When a counter's top bit falls from 1 to 0, the matching overflow flag is set. The single interrupt line stays high while any flagged counter also has its interrupt enabled.

Top module: `pmon_bank`

## Requirements
- R1: The bank has NUM_CTR general counters (1 to 31; other values stop elaboration) at indices 0..NUM_CTR-1, and the cycle counter at index 31 of the enable, overflow and interrupt-enable words. Bits of those words with no counter always read 0, and a value write to a missing counter index has no effect.
- R2: After reset every register, counter and flag reads 0 and irq is low. Addresses: 0x00 control, 0x01 count enable, 0x02 overflow flags, 0x03 interrupt enable, 0x04 software increment, 0x05/0x06 cycle counter low/high word, 0x20+i configuration of counter i, 0x40+i value of counter i.
- R3: A counter advances only in a cycle where control bit 0 and its own count-enable bit are both 1. A select code k in 1..NUM_EVT (configuration bits 7:0) counts one per clock in which evt_in[k-1] is high. Other event lines have no effect.
- R4: An increment that takes a counter's most significant bit from 1 to 0 sets its overflow flag. That bit is bit 31 for a general counter and bit 63 for the cycle counter. A change from 0x7FFFFFFF to 0x80000000 sets no flag.
- R5: At user level (cur_lvl=0) a counter is skipped when, in secure state, its U bit (configuration bit 8) is 1. In non-secure state it is skipped when U differs from NSU (bit 10).
- R6: At kernel level (cur_lvl=1) a counter is skipped when, in secure state, its P bit (bit 9) is 1. In non-secure state it is skipped when P differs from NSK (bit 11).
- R7: At hypervisor level (cur_lvl=2) a counter is skipped when P differs from M (bit 12). At cur_lvl=3 no counter is skipped.
- R8: Writing 1 to bit i of the software-increment register adds one to counter i only if it is enabled and its select code is 0. That register reads 0.
- R9: A control write with bit 1 set clears all general counters and leaves the cycle counter. Bit 2 clears the cycle counter and its remainder. Both bits read back 0.
- R10: With control bit 3 set, the cycle counter advances once per 64 enabled clocks. The partial count is kept between run periods. With bit 3 clear it advances once per enabled clock.
- R11: irq is high while any overflow flag and its interrupt-enable bit are both 1. Writing 1 to a flag bit clears it. A new overflow on a counter whose flag is already set leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| evt_in | input | NUM_EVT | Event pulse lines |
| cur_lvl | input | 2 | Current privilege level (0 user, 1 kernel, 2 hypervisor, 3 monitor) |
| cur_secure | input | 1 | Current security state is secure |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest states to reach from the ports are the two overflow points. A 32-bit counter would need billions of events, and the 64-bit cycle counter even more. The stimulus loads values just below the top through the value registers and then applies one or two events, so the falling top bit lands on a known edge. The divided cycle mode is reached by running exact numbers of enabled clocks between two control writes. This lets the carried remainder be checked across two separate run periods.

// File: rtl/pmon_pkg.sv
// Shared constants, configuration word layout and the privilege filter rule
// for the performance event counter bank. Assumes a 32-bit register port.
package pmon_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 7;
    localparam int SEL_W  = 8;
    localparam int CYC_IDX = 31;

    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h00;
    localparam logic [ADDR_W-1:0] A_CNTEN = 7'h01;
    localparam logic [ADDR_W-1:0] A_OVF   = 7'h02;
    localparam logic [ADDR_W-1:0] A_INTEN = 7'h03;
    localparam logic [ADDR_W-1:0] A_SWINC = 7'h04;
    localparam logic [ADDR_W-1:0] A_CYCLO = 7'h05;
    localparam logic [ADDR_W-1:0] A_CYCHI = 7'h06;
    localparam logic [1:0] RGN_CFG = 2'b01;
    localparam logic [1:0] RGN_VAL = 2'b10;

    localparam int CB_RUN   = 0;
    localparam int CB_EVCLR = 1;
    localparam int CB_CYCLR = 2;
    localparam int CB_DIV   = 3;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } plevel_e;

    // bit 12 m, 11 nsk, 10 nsu, 9 p, 8 u, 7:0 select
    typedef struct packed {
        logic             m;
        logic             nsk;
        logic             nsu;
        logic             p;
        logic             u;
        logic [SEL_W-1:0] sel;
    } evcfg_t;

    localparam int CFG_W = $bits(evcfg_t);

    // True when the configuration excludes counting at this level and state.
    function automatic logic lvl_blocked(evcfg_t c, plevel_e lv, logic sec);
        case (lv)
            LVL_USER: return sec ? c.u : (c.u != c.nsu);
            LVL_KERN: return sec ? c.p : (c.p != c.nsk);
            LVL_HYP:  return c.p != c.m;
            default:  return 1'b0;
        endcase
    endfunction

    // Mask of the index bits that have a counter behind them.
    function automatic logic [REG_W-1:0] impl_mask(int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < REG_W - 1; k++)
            if (k < n) m[k] = 1'b1;
        m[CYC_IDX] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pmon_evt_ctr.sv
// One general event counter with its configuration word. It picks an event
// line or the software-increment strobe, applies the privilege filter and
// reports a top-bit wrap. Assumes GEN_W <= 32 and single-cycle event pulses.
module pmon_evt_ctr
    import pmon_pkg::*;
#(
    parameter int GEN_W   = 32,
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               sw_hit,
    input  logic [1:0]         lvl,
    input  logic               sec,
    input  logic               cfg_we,
    input  evcfg_t             cfg_wdata,
    input  logic               val_we,
    input  logic [GEN_W-1:0]   val_wdata,
    input  logic               clr,
    output evcfg_t             cfg_q,
    output logic [GEN_W-1:0]   cnt_q,
    output logic               wrap
);
    localparam int MSB = GEN_W - 1;

    logic             sel_hit;
    logic             bump;
    logic [GEN_W-1:0] sum;

    // Select the source named by the configuration word.
    always_comb begin
        sel_hit = 1'b0;
        if (cfg_q.sel == '0) sel_hit = sw_hit;
        for (int k = 0; k < NUM_EVT; k++)
            if (cfg_q.sel == SEL_W'(k + 1)) sel_hit = evt_in[k];
    end

    // Decide whether this cycle adds one and whether that wraps the top bit.
    always_comb begin
        bump = run && sel_hit && !lvl_blocked(cfg_q, plevel_e'(lvl), sec);
        sum  = cnt_q + GEN_W'(1);
        wrap = bump && !clr && !val_we && cnt_q[MSB] && !sum[MSB];
    end

    // Configuration and count registers; clear beats write beats increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= cfg_wdata;
            if (clr)         cnt_q <= '0;
            else if (val_we) cnt_q <= val_wdata;
            else if (bump)   cnt_q <= sum;
        end
    end

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr && !val_we) |=> $stable(cnt_q));
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/pmon_cyc_ctr.sv
// Dedicated cycle counter with an optional divide-by-2**DIV_LOG prescale.
// The prescale remainder survives stop and mode changes so no clocks are lost.
// Assumes 33 <= CYC_W <= 64 and a 32-bit word split into low and high halves.
module pmon_cyc_ctr #(
    parameter int CYC_W   = 64,
    parameter int DIV_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div,
    input  logic             clr,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [31:0]      wdata,
    output logic [CYC_W-1:0] cnt_q,
    output logic             wrap
);
    localparam int MSB = CYC_W - 1;

    logic [DIV_LOG-1:0] rem_q;
    logic               tick;
    logic               wr_any;
    logic [CYC_W-1:0]   sum;
    logic [CYC_W-1:0]   wr_val;

    // Work out the step for this cycle and the merged write value.
    always_comb begin
        tick   = run && (!div || (rem_q == '1));
        wr_any = we_lo || we_hi;
        sum    = cnt_q + CYC_W'(1);
        wrap   = tick && !clr && !wr_any && cnt_q[MSB] && !sum[MSB];
        wr_val = cnt_q;
        if (we_lo) wr_val[31:0] = wdata;
        if (we_hi) wr_val[CYC_W-1:32] = wdata[CYC_W-33:0];
    end

    // Prescale remainder and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            cnt_q <= '0;
        end else begin
            if (clr)             rem_q <= '0;
            else if (run && div) rem_q <= rem_q + DIV_LOG'(1);
            if (clr)         cnt_q <= '0;
            else if (wr_any) cnt_q <= wr_val;
            else if (tick)   cnt_q <= sum;
        end
    end

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_any) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CYC_W'(1)));
    a_r10_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (div && run && rem_q != '1 && !clr && !wr_any) |=> $stable(cnt_q));
endmodule

// File: rtl/pmon_bank.sv
// Performance event counter bank: register decode, control, enable, overflow
// and interrupt-enable words, NUM_CTR general counters and one cycle counter.
// Assumes a single-cycle write strobe and reads decoded combinationally.
module pmon_bank
    import pmon_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 8,
    parameter int GEN_W   = 32,
    parameter int CYC_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [6:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [1:0]         cur_lvl,
    input  logic               cur_secure,
    output logic               irq
);
    localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_CTR);

    if (NUM_CTR < 1 || NUM_CTR > 31) begin : g_bad_cfg
        $error("pmon_bank: NUM_CTR must be 1..31");
    end

    logic             ctl_run_q, ctl_div_q;
    logic [REG_W-1:0] cnten_q, ovf_q, inten_q, ovf_set;
    logic             wr_ctl, wr_ovf, wr_sw, ev_clr, cy_clr;
    logic [GEN_W-1:0] ctr_val [NUM_CTR];
    evcfg_t           ctr_cfg [NUM_CTR];
    logic [CYC_W-1:0] cyc_val;
    logic [4:0]       idx;

    // Decode the write strobes that more than one register uses.
    always_comb begin
        idx    = bus_addr[4:0];
        wr_ctl = bus_we && bus_addr == A_CTRL;
        wr_ovf = bus_we && bus_addr == A_OVF;
        wr_sw  = bus_we && bus_addr == A_SWINC;
        ev_clr = wr_ctl && bus_wdata[CB_EVCLR];
        cy_clr = wr_ctl && bus_wdata[CB_CYCLR];
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        pmon_evt_ctr #(.GEN_W(GEN_W), .NUM_EVT(NUM_EVT)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (ctl_run_q && cnten_q[i]),
            .evt_in    (evt_in),
            .sw_hit    (wr_sw && bus_wdata[i]),
            .lvl       (cur_lvl),
            .sec       (cur_secure),
            .cfg_we    (bus_we && bus_addr[6:5] == RGN_CFG && idx == 5'(i)),
            .cfg_wdata (evcfg_t'(bus_wdata[CFG_W-1:0])),
            .val_we    (bus_we && bus_addr[6:5] == RGN_VAL && idx == 5'(i)),
            .val_wdata (bus_wdata[GEN_W-1:0]),
            .clr       (ev_clr),
            .cfg_q     (ctr_cfg[i]),
            .cnt_q     (ctr_val[i]),
            .wrap      (ovf_set[i])
        );
    end

    for (genvar j = NUM_CTR; j < CYC_IDX; j++) begin : g_absent
        assign ovf_set[j] = 1'b0;
    end

    pmon_cyc_ctr #(.CYC_W(CYC_W), .DIV_LOG(6)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_run_q && cnten_q[CYC_IDX]),
        .div   (ctl_div_q),
        .clr   (cy_clr),
        .we_lo (bus_we && bus_addr == A_CYCLO),
        .we_hi (bus_we && bus_addr == A_CYCHI),
        .wdata (bus_wdata),
        .cnt_q (cyc_val),
        .wrap  (ovf_set[CYC_IDX])
    );

    // Control, enable, interrupt-enable and overflow-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_run_q <= 1'b0;
            ctl_div_q <= 1'b0;
            cnten_q   <= '0;
            inten_q   <= '0;
            ovf_q     <= '0;
        end else begin
            if (wr_ctl) begin
                ctl_run_q <= bus_wdata[CB_RUN];
                ctl_div_q <= bus_wdata[CB_DIV];
            end
            if (bus_we && bus_addr == A_CNTEN) cnten_q <= bus_wdata & IMPL;
            if (bus_we && bus_addr == A_INTEN) inten_q <= bus_wdata & IMPL;
            ovf_q <= ((ovf_q & ~(wr_ovf ? bus_wdata : '0)) | ovf_set) & IMPL;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  begin
                bus_rdata[CB_RUN] = ctl_run_q;
                bus_rdata[CB_DIV] = ctl_div_q;
            end
            A_CNTEN: bus_rdata = cnten_q;
            A_OVF:   bus_rdata = ovf_q;
            A_INTEN: bus_rdata = inten_q;
            A_CYCLO: bus_rdata = cyc_val[31:0];
            A_CYCHI: bus_rdata = 32'(cyc_val[CYC_W-1:32]);
            default: begin
                for (int k = 0; k < NUM_CTR; k++) begin
                    if (idx == 5'(k) && bus_addr[6:5] == RGN_CFG) bus_rdata = 32'(ctr_cfg[k]);
                    if (idx == 5'(k) && bus_addr[6:5] == RGN_VAL) bus_rdata = 32'(ctr_val[k]);
                end
            end
        endcase
    end

    assign irq = |(ovf_q & inten_q);

    a_r4_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set != '0) |=> ((ovf_q & $past(ovf_set)) == $past(ovf_set)));
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ovf && ((bus_wdata & ~ovf_set & ovf_q) != '0))
        |=> ((ovf_q & $past(bus_wdata & ~ovf_set)) == '0));
    a_r11_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (inten_q == '0) |-> !irq);
endmodule

// File: tb/sim_pmon_bank.sv
`timescale 1ns/1ps
module sim_pmon_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_in = '0;
    logic [1:0]  cur_lvl = 2'd3;
    logic        cur_secure = 1'b1;
    logic        irq;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pmon_bank #(.NUM_CTR(4), .NUM_EVT(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .cur_lvl(cur_lvl), .cur_secure(cur_secure), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rdchk(string req, logic [6:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(logic [7:0] m, int n);
        for (int k = 0; k < n; k++) begin
            evt_in = m;
            @(negedge clk);
            evt_in = '0;
        end
    endtask

    task automatic t_reset;
        rdchk("R2 ctrl", 7'h00, 0);
        rdchk("R2 cnten", 7'h01, 0);
        rdchk("R2 ovf", 7'h02, 0);
        rdchk("R2 ctr0", 7'h40, 0);
        rdchk("R2 cyc", 7'h05, 0);
        chk("R2 irq", 32'(irq), 0);
    endtask

    task automatic t_gate;
        wr(7'h20, 32'h01);
        wr(7'h01, 32'h1);
        pulse(8'h01, 3);
        rdchk("R3 global off", 7'h40, 0);
        wr(7'h00, 32'h1);
        pulse(8'h01, 5);
        rdchk("R3 counts", 7'h40, 5);
        pulse(8'h02, 2);
        rdchk("R3 other line", 7'h40, 5);
        wr(7'h01, 32'h0);
        pulse(8'h01, 2);
        rdchk("R3 own bit off", 7'h40, 5);
        wr(7'h01, 32'h1);
    endtask

    task automatic t_unimpl;
        wr(7'h01, 32'hFFFF_FFFF);
        rdchk("R1 cnten mask", 7'h01, 32'h8000_000F);
        wr(7'h03, 32'hFFFF_FFFF);
        rdchk("R1 inten mask", 7'h03, 32'h8000_000F);
        wr(7'h45, 32'h1234);
        rdchk("R1 missing ctr", 7'h45, 0);
        wr(7'h01, 32'h1);
        wr(7'h03, 32'h0);
    endtask

    task automatic t_filter;
        int e = 0;
        wr(7'h01, 32'h3);
        cur_lvl = 2'd0; cur_secure = 1'b1;
        wr(7'h21, 32'h102);
        pulse(8'h02, 1);
        rdchk("R5 secure U", 7'h41, e);
        cur_secure = 1'b0;
        pulse(8'h02, 1);
        rdchk("R5 U!=NSU", 7'h41, e);
        wr(7'h21, 32'h502);
        pulse(8'h02, 1); e++;
        rdchk("R5 U==NSU", 7'h41, e);
        cur_secure = 1'b1; wr(7'h21, 32'h002);
        pulse(8'h02, 1); e++;
        rdchk("R5 secure clear", 7'h41, e);
        cur_lvl = 2'd1; wr(7'h21, 32'h202);
        pulse(8'h02, 1);
        rdchk("R6 secure P", 7'h41, e);
        cur_secure = 1'b0;
        pulse(8'h02, 1);
        rdchk("R6 P!=NSK", 7'h41, e);
        wr(7'h21, 32'hA02);
        pulse(8'h02, 1); e++;
        rdchk("R6 P==NSK", 7'h41, e);
        cur_lvl = 2'd2; wr(7'h21, 32'h202);
        pulse(8'h02, 1);
        rdchk("R7 P!=M", 7'h41, e);
        wr(7'h21, 32'h1202);
        pulse(8'h02, 1); e++;
        rdchk("R7 P==M", 7'h41, e);
        cur_lvl = 2'd3; cur_secure = 1'b1; wr(7'h21, 32'h1F02);
        pulse(8'h02, 1); e++;
        rdchk("R7 level 3", 7'h41, e);
        rdchk("R5 cfg readback", 7'h21, 32'h1F02);
    endtask

    task automatic t_swinc;
        wr(7'h22, 32'h0);
        wr(7'h23, 32'h0);
        wr(7'h01, 32'h7);
        wr(7'h04, 32'hC);
        rdchk("R8 selected", 7'h42, 1);
        rdchk("R8 disabled", 7'h43, 0);
        wr(7'h04, 32'h4);
        wr(7'h04, 32'h4);
        rdchk("R8 repeat", 7'h42, 3);
        wr(7'h04, 32'h1);
        rdchk("R8 not sw select", 7'h40, 5);
        rdchk("R8 reads zero", 7'h04, 0);
    endtask

    task automatic t_overflow;
        wr(7'h40, 32'h7FFF_FFFF);
        pulse(8'h01, 1);
        rdchk("R4 no flag mid", 7'h02, 0);
        wr(7'h40, 32'hFFFF_FFFE);
        pulse(8'h01, 1);
        rdchk("R4 before", 7'h02, 0);
        pulse(8'h01, 1);
        rdchk("R4 wrapped", 7'h40, 0);
        rdchk("R4 flag", 7'h02, 1);
        chk("R11 masked", 32'(irq), 0);
        wr(7'h03, 32'h1);
        chk("R11 raised", 32'(irq), 1);
        wr(7'h40, 32'hFFFF_FFFF);
        pulse(8'h01, 1);
        rdchk("R11 already set", 7'h02, 1);
        wr(7'h02, 32'h2);
        rdchk("R11 other bit", 7'h02, 1);
        wr(7'h02, 32'h1);
        rdchk("R11 cleared", 7'h02, 0);
        chk("R11 irq low", 32'(irq), 0);
    endtask

    task automatic t_ctl_reset;
        pulse(8'h01, 1);
        wr(7'h05, 32'd100);
        wr(7'h06, 32'd5);
        wr(7'h00, 32'h3);
        rdchk("R9 ctr0", 7'h40, 0);
        rdchk("R9 ctr1", 7'h41, 0);
        rdchk("R9 cyc kept", 7'h05, 100);
        rdchk("R9 ctrl read", 7'h00, 1);
        wr(7'h00, 32'h4);
        rdchk("R9 cyc lo", 7'h05, 0);
        rdchk("R9 cyc hi", 7'h06, 0);
    endtask

    task automatic t_cycle;
        wr(7'h01, 32'h8000_0000);
        wr(7'h00, 32'h1);
        repeat (19) @(negedge clk);
        wr(7'h00, 32'h0);
        rdchk("R10 undivided", 7'h05, 20);
        wr(7'h00, 32'h4);
        wr(7'h00, 32'h9);
        repeat (129) @(negedge clk);
        wr(7'h00, 32'h8);
        rdchk("R10 divided", 7'h05, 2);
        wr(7'h00, 32'h9);
        repeat (61) @(negedge clk);
        wr(7'h00, 32'h8);
        rdchk("R10 remainder kept", 7'h05, 3);
        wr(7'h00, 32'h0);
        wr(7'h05, 32'hFFFF_FFFF);
        wr(7'h06, 32'hFFFF_FFFF);
        wr(7'h03, 32'h8000_0000);
        wr(7'h00, 32'h1);
        wr(7'h00, 32'h0);
        rdchk("R4 cycle wrap", 7'h06, 0);
        rdchk("R4 cycle flag", 7'h02, 32'h8000_0000);
        chk("R11 cycle irq", 32'(irq), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_unimpl();
        t_filter();
        t_swinc();
        t_overflow();
        t_ctl_reset();
        t_cycle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule